// File: doc/BRIEF.md
# Flash Converter Digital Output Stage

This block is the digital back end of an 8-bit parallel converter. Every clock it receives a 255-bit thermometer vector from a bank of comparators, plus one extra comparator bit that trips only when the analog input is above full scale. The high half of the clock is the balance phase and the low half is the sample phase. The comparator vector settles during the low half and is captured on the rising edge. In that same step it is reduced to a one-hot vector. On the following falling edge the one-hot vector is turned into a binary code. One falling edge later the code and the over-range flag are loaded into the output registers. A sample therefore appears on the outputs one and a half clock cycles after it was captured.

The outputs can be turned off by two enable pins with different effects. `chip_en` (active high) controls both outputs. `data_oe_n` (active low) controls only the code bus. The flag output stays driven while the chip is enabled, whatever `data_oe_n` does. The enable pins are decoded into three drive states: DRV_ALL, DRV_FLAG and DRV_OFF. The decode is purely combinational, and every input combination moves the block directly into its state. `chip_en`=0 goes to DRV_OFF. `chip_en`=1 with `data_oe_n`=1 goes to DRV_FLAG. `chip_en`=1 with `data_oe_n`=0 goes to DRV_ALL. A disabled output floats to `z`. Two drive-indicator outputs report which outputs are being driven.

Top module: `flash_out_stage`

## Requirements
- R1: A synchronous active-high reset clears every pipeline and output register, so with both outputs driven the code reads 0x00 and the flag reads 0.
- R2: When `therm_in[k-1:0]` are all 1 and the remaining bits are 0 (monotonic thermometer), the code equals k, for every k from 0 to 255. All zeros gives 0x00 and all ones gives 0xFF.
- R3: Inputs sampled at rising edge n reach the outputs at the falling edge 1.5 cycles later. Half a cycle after that rising edge, the outputs still hold the previous result.
- R4: When `ovr_cmp` is 1 at the sampling edge, the flag output reads 1 and the code saturates at 0xFF, whatever the thermometer bits are.
- R5: For a non-monotonic vector, the code equals one plus the index of the highest set `therm_in` bit. A vector with no bits set gives 0.
- R6: With `chip_en`=1 and `data_oe_n`=0 (DRV_ALL), both `code_drive` and `ovr_drive` are 1.
- R7: With `chip_en`=1 and `data_oe_n`=1 (DRV_FLAG), `code_drive` is 0 and `ovr_drive` is 1, and `ovr_out` still carries the flag. The code bus is never driven while the flag is not.
- R8: With `chip_en`=0 (DRV_OFF), both drive indicators are 0 for either value of `data_oe_n`.
- R9: The enables act only on the drive and leave the pipeline untouched. A conversion made while disabled reads correctly once the outputs are re-enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; high half balances, low half samples |
| rst | input | 1 | Synchronous reset, active high |
| therm_in | input | 255 | Comparator thermometer vector, bit i set when input exceeds tap i+1 |
| ovr_cmp | input | 1 | Over-range comparator bit |
| data_oe_n | input | 1 | Code bus enable, active low |
| chip_en | input | 1 | Master output enable, active high |
| code_out | output | 8 | Registered binary code, `z` when not driven |
| ovr_out | output | 1 | Registered over-range flag, `z` when not driven |
| code_drive | output | 1 | 1 while `code_out` is driven |
| ovr_drive | output | 1 | 1 while `ovr_out` is driven |

## Verification
The encoder is first swept over every monotonic level from 0 to 255. This shows whether the one-hot reduction and the binary conversion count correctly at each tap, including the two ends of the range. A short table of irregular vectors follows: a gap inside the ones, an isolated high bit and a stray top bit. These tell the highest-position rule apart from OR-based or lowest-position encodings. Over-range vectors with empty and full thermometers separate saturation from plain encoding. Back-to-back samples are checked one half cycle early to pin the latency, and all four enable combinations are applied with a conversion made while disabled.

// File: rtl/flash_pkg.sv
package flash_pkg;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_FLAG = 2'd1,
        DRV_ALL  = 2'd2
    } drive_mode_t;
endpackage

// File: rtl/flash_therm_stage.sv
// Rising-edge stage: captures comparators, reduces thermometer to one-hot.
module flash_therm_stage #(
    parameter int W = flash_pkg::CODE_W,
    localparam int LEVELS = 1 << W,
    localparam int TAPS = LEVELS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAPS-1:0]   therm,
    input  logic              ovr,
    output logic [LEVELS-1:0] onehot_q,
    output logic              ovr_q
);
    // Extended vector: an implied 1 below tap 0 and an implied 0 above the top.
    logic [LEVELS:0]   ext;
    logic [LEVELS-1:0] onehot_d;

    assign ext = {1'b0, therm, 1'b1};

    for (genvar i = 0; i < LEVELS; i++) begin : g_edge
        assign onehot_d[i] = ext[i] & ~ext[i+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            onehot_q <= '0;
            ovr_q    <= 1'b0;
        end else begin
            onehot_q <= onehot_d;
            ovr_q    <= ovr;
        end
    end

    // R5: after reset there is always at least one candidate position
    p_candidate_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(onehot_q) != 0));

    // R1: reset empties the first stage
    p_reset_stage1_r1: assert property (@(posedge clk)
        rst |=> (onehot_q == '0 && ovr_q == 1'b0));
endmodule

// File: rtl/flash_bin_stage.sv
// Falling-edge stage: highest one-hot position to binary, saturating on over-range.
module flash_bin_stage #(
    parameter int W = flash_pkg::CODE_W,
    localparam int LEVELS = 1 << W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] onehot,
    input  logic              ovr,
    output logic [W-1:0]      code_q,
    output logic              ovr_q
);
    logic [W-1:0] code_c;

    always_comb begin
        code_c = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (onehot[i]) code_c = W'(i);
        end
        if (ovr) code_c = '1;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            code_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            code_q <= code_c;
            ovr_q  <= ovr;
        end
    end
endmodule

// File: rtl/flash_out_drive.sv
// Output registers and enable decode into drive states.
module flash_out_drive #(
    parameter int W = flash_pkg::CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code_in,
    input  logic         ovr_in,
    input  logic         data_oe_n,
    input  logic         chip_en,
    output logic [W-1:0] code_out,
    output logic         ovr_out,
    output logic         code_drive,
    output logic         ovr_drive
);
    import flash_pkg::*;

    logic [W-1:0] data_q;
    logic         flag_q;
    drive_mode_t  mode;
    logic         armed;

    always_ff @(negedge clk) begin
        if (rst) begin
            data_q <= '0;
            flag_q <= 1'b0;
            armed  <= 1'b0;
        end else begin
            data_q <= code_in;
            flag_q <= ovr_in;
            armed  <= 1'b1;
        end
    end

    // Drive-state selection
    always_comb begin
        unique casez ({chip_en, data_oe_n})
            2'b10:   mode = DRV_ALL;
            2'b11:   mode = DRV_FLAG;
            2'b0?:   mode = DRV_OFF;
            default: mode = DRV_OFF;
        endcase
    end

    // Outputs per drive state
    always_comb begin
        unique case (mode)
            DRV_ALL:  begin code_drive = 1'b1; ovr_drive = 1'b1; end
            DRV_FLAG: begin code_drive = 1'b0; ovr_drive = 1'b1; end
            default:  begin code_drive = 1'b0; ovr_drive = 1'b0; end
        endcase
    end

    assign code_out = code_drive ? data_q : 'z;
    assign ovr_out  = ovr_drive  ? flag_q : 1'bz;

    // R7: the code bus is never driven without the flag
    always_comb begin
        p_bus_needs_flag_r7: assert (!code_drive || ovr_drive);
    end

    // R4: a set flag always comes with a saturated code
    p_saturate_r4: assert property (@(negedge clk) disable iff (rst)
        flag_q |-> (data_q == '1));

    // R3: output register holds what the encoder produced one falling edge earlier
    p_latency_r3: assert property (@(negedge clk) disable iff (rst)
        armed |-> (data_q == $past(code_in) && flag_q == $past(ovr_in)));
endmodule

// File: rtl/flash_out_stage.sv
module flash_out_stage #(
    parameter int W = flash_pkg::CODE_W,
    localparam int LEVELS = 1 << W,
    localparam int TAPS = LEVELS - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TAPS-1:0] therm_in,
    input  logic            ovr_cmp,
    input  logic            data_oe_n,
    input  logic            chip_en,
    output logic [W-1:0]    code_out,
    output logic            ovr_out,
    output logic            code_drive,
    output logic            ovr_drive
);
    logic [LEVELS-1:0] onehot;
    logic              ovr_s1;
    logic [W-1:0]      code_s2;
    logic              ovr_s2;

    flash_therm_stage #(.W(W)) u_therm (
        .clk      (clk),
        .rst      (rst),
        .therm    (therm_in),
        .ovr      (ovr_cmp),
        .onehot_q (onehot),
        .ovr_q    (ovr_s1)
    );

    flash_bin_stage #(.W(W)) u_bin (
        .clk    (clk),
        .rst    (rst),
        .onehot (onehot),
        .ovr    (ovr_s1),
        .code_q (code_s2),
        .ovr_q  (ovr_s2)
    );

    flash_out_drive #(.W(W)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .code_in    (code_s2),
        .ovr_in     (ovr_s2),
        .data_oe_n  (data_oe_n),
        .chip_en    (chip_en),
        .code_out   (code_out),
        .ovr_out    (ovr_out),
        .code_drive (code_drive),
        .ovr_drive  (ovr_drive)
    );
endmodule

// File: tb/tb_flash_out_stage.sv
`timescale 1ns/100ps
module tb_flash_out_stage;
    localparam real HALF = 2.5;   // 200 MHz

    typedef struct packed {
        logic [254:0] th;
        logic         ov;
        logic [7:0]   code;
        logic         flag;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{th: 255'd0,                          ov: 1'b0, code: 8'h00, flag: 1'b0}, // R2 empty
        '{th: {255{1'b1}},                     ov: 1'b0, code: 8'hFF, flag: 1'b0}, // R2 full
        '{th: {255{1'b1}} >> 127,              ov: 1'b0, code: 8'h80, flag: 1'b0}, // R2 mid
        '{th: 255'd1,                          ov: 1'b0, code: 8'h01, flag: 1'b0}, // R2 one tap
        '{th: 255'(10'h3EF),                   ov: 1'b0, code: 8'h0A, flag: 1'b0}, // R5 gap
        '{th: 255'(1) << 200,                  ov: 1'b0, code: 8'hC9, flag: 1'b0}, // R5 lone bit
        '{th: (255'(1) << 254) | ({255{1'b1}} >> 155), ov: 1'b0, code: 8'hFF, flag: 1'b0}, // R5 top stray
        '{th: {255{1'b1}},                     ov: 1'b1, code: 8'hFF, flag: 1'b1}, // R4 full
        '{th: 255'd0,                          ov: 1'b1, code: 8'hFF, flag: 1'b1}  // R4 empty
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [254:0] therm_in = '0;
    logic         ovr_cmp = 1'b0;
    logic         data_oe_n = 1'b0;
    logic         chip_en = 1'b1;
    logic [7:0]   code_out;
    logic         ovr_out;
    logic         code_drive;
    logic         ovr_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(HALF) clk = ~clk;

    flash_out_stage dut (
        .clk(clk), .rst(rst), .therm_in(therm_in), .ovr_cmp(ovr_cmp),
        .data_oe_n(data_oe_n), .chip_en(chip_en), .code_out(code_out),
        .ovr_out(ovr_out), .code_drive(code_drive), .ovr_drive(ovr_drive)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; result is valid just after the second falling edge.
    task automatic convert(input logic [254:0] th, input logic ov);
        therm_in = th;
        ovr_cmp  = ov;
        @(negedge clk); #1;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        // R1: reset state with both outputs driven
        check("R1 code after reset", 32'(code_out), 32'h00);
        check("R1 flag after reset", 32'(ovr_out), 32'h0);

        // R2/R4/R5 table walk
        foreach (VECS[i]) begin
            convert(VECS[i].th, VECS[i].ov);
            check($sformatf("R2/R4/R5 vec %0d code", i), 32'(code_out), 32'(VECS[i].code));
            check($sformatf("R2/R4/R5 vec %0d flag", i), 32'(ovr_out), 32'(VECS[i].flag));
        end

        // R2: full monotonic sweep
        for (int k = 0; k < 256; k++) begin
            convert({255{1'b1}} >> (255 - k), 1'b0);
            check($sformatf("R2 level %0d", k), 32'(code_out), 32'(k));
        end

        // R3: latency, previous value still visible half a cycle after capture
        convert(255'(16'hFFFF), 1'b0);
        therm_in = 255'(32'hFFFF_FFFF);
        @(negedge clk); #1;
        check("R3 early sample holds old code", 32'(code_out), 32'h10);
        @(negedge clk); #1;
        check("R3 new code after 1.5 cycles", 32'(code_out), 32'h20);

        // R6/R7/R8: drive states
        convert(255'd0, 1'b1);
        chip_en = 1'b1; data_oe_n = 1'b0; #1;
        check("R6 code_drive", 32'(code_drive), 32'h1);
        check("R6 ovr_drive", 32'(ovr_drive), 32'h1);
        chip_en = 1'b1; data_oe_n = 1'b1; #1;
        check("R7 code_drive", 32'(code_drive), 32'h0);
        check("R7 ovr_drive", 32'(ovr_drive), 32'h1);
        check("R7 flag still driven", 32'(ovr_out), 32'h1);
        chip_en = 1'b0; data_oe_n = 1'b1; #1;
        check("R8 code_drive oe_n=1", 32'(code_drive), 32'h0);
        check("R8 ovr_drive oe_n=1", 32'(ovr_drive), 32'h0);
        chip_en = 1'b0; data_oe_n = 1'b0; #1;
        check("R8 code_drive oe_n=0", 32'(code_drive), 32'h0);
        check("R8 ovr_drive oe_n=0", 32'(ovr_drive), 32'h0);

        // R9: convert while disabled, then re-enable
        @(negedge clk); #1;
        convert({255{1'b1}} >> (255 - 77), 1'b0);
        chip_en = 1'b1; data_oe_n = 1'b0; #1;
        check("R9 code after re-enable", 32'(code_out), 32'd77);
        check("R9 flag after re-enable", 32'(ovr_out), 32'h0);

        // R1: reset in mid-run clears outputs
        @(negedge clk); #1;
        convert({255{1'b1}} >> 55, 1'b1);
        rst = 1'b1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        rst = 1'b0;
        check("R1 code after mid-run reset", 32'(code_out), 32'h00);
        check("R1 flag after mid-run reset", 32'(ovr_out), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(2.0 * HALF * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule